// File: doc/BRIEF.md
# Address-mapped NAND bus adapter

The adapter sits between a simple request/acknowledge memory bus and one 8-bit raw NAND flash device, or one of two devices, chosen by a routing bit. The lower half of the byte address space is a data window. Each access there moves one byte to or from the flash. The address bits of that access decide which NAND control lines are raised for its duration: a command byte, an address byte, a data byte and a spare-area access are all plain bus accesses to different addresses. The upper half of the address space holds a control word and a status word.

Every window access runs a fixed pin sequence timed in bus clocks. First comes a strobe phase with the write or read enable low. Then a hold phase, during which write data stays on the I/O lines. Then a recovery phase with the lines released. The bus acknowledge is raised only after all three phases, so the host stalls for the whole sequence. The status word carries a synchronized copy of the ready/busy pin and a sticky completion flag that software polls after each command or address byte.

Top module: `nand_bus_bridge`

## Requirements
- R1: During a window access (byte address bit 7 = 0), byte address bit 3 drives the command latch line and bit 2 drives the address latch line. Both are active-high and are low outside a transfer.
- R2: During a window access, address bit 5 asserts the spare-area select and bit 6 asserts write protect. Both sit at their inactive level outside a transfer.
- R3: A window write holds the write enable low for WR_WAIT*CMULT clocks. It drives the byte on the I/O lines with output enable high for (WR_WAIT+HOLD)*CMULT clocks. The acknowledge follows after a further RECOV*CMULT clocks, 17 clocks after acceptance with the defaults.
- R4: A window read holds the read enable low for RD_WAIT*CMULT clocks. It never drives the I/O lines. It returns in rdata_o[7:0] the I/O value sampled at the clock edge where the read enable rises.
- R5: ready_o stays low from reset and while a transfer is in progress. It is a single-cycle pulse that ends each access.
- R6: Status bit 3 reads 0 after reset. It clears when a window transfer starts and sets once that transfer completes.
- R7: Status bit 0 reports the selected ready/busy input after a two-flop synchronizer.
- R8: Control bit 0 (flash mode) together with control bit 20 (device enable) asserts the chip enable. With flash mode set, a window access with address bit 4 also asserts it for the transfer. With flash mode clear, chip enable stays inactive.
- R9: Control bit 10 moves the chip enable output from line 0 to line 1. Control bit 8 moves the ready/busy input used for status bit 0 from line 0 to line 1.
- R10: Control bits 4, 5 and 6 make chip enable, spare select and write protect active-low when set, and active-high when clear.
- R11: The status word is at byte address 0x80 and the control word at 0x84. Register accesses are acknowledged one cycle after acceptance. The control word resets to 0, and only bits 0, 4, 5, 6, 8, 10 and 20 are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte address bits 7:2 |
| wdata_i | input | 32 | Write data; window writes use bits 7:0 |
| rdata_o | output | 32 | Read data, valid while ready_o is high |
| ready_o | output | 1 | Access acknowledge pulse |
| nand_ce_o | output | 2 | Chip enable lines 0 and 1 |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_se_o | output | 1 | Spare-area select |
| nand_wp_o | output | 1 | Write protect |
| nand_we_n_o | output | 1 | Write enable strobe, active low |
| nand_re_n_o | output | 1 | Read enable strobe, active low |
| nand_io_i | input | 8 | Flash I/O input |
| nand_io_o | output | 8 | Flash I/O output |
| nand_io_oe_o | output | 1 | I/O output enable |
| nand_rb_i | input | 2 | Asynchronous ready/busy inputs, lines 0 and 1 |

## Verification
Several properties are checked on every cycle:
- Write data stays driven at the moment the write strobe rises.
- The I/O lines are never driven while the read strobe is low.
- The acknowledge never appears during a transfer and never lasts two cycles.
- The completion flag is clear throughout a transfer and set right after one.
- Chip enable is inactive whenever flash mode is off.

Only the bench scenarios can show the exact phase lengths and the total access latency. The same holds for which control lines each window address raises, and for the read byte being the value present before the read strobe rose rather than after. Polarity inversion, line routing and the synchronized ready/busy value likewise need directed scenarios.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_STRB, ST_HOLD, ST_RCV, ST_ACK} seq_st_e;

  // control word bit positions
  localparam int CTL_NANDM  = 0;
  localparam int CTL_CSP    = 4;
  localparam int CTL_SEP    = 5;
  localparam int CTL_WPP    = 6;
  localparam int CTL_INSEL  = 8;
  localparam int CTL_OUTSEL = 10;
  localparam int CTL_CE     = 20;

  // status word bit positions
  localparam int STS_RB   = 0;
  localparam int STS_DONE = 3;

  // window address bit positions (byte address)
  localparam int A_ALE = 2;
  localparam int A_CLE = 3;
  localparam int A_CS  = 4;
  localparam int A_SE  = 5;
  localparam int A_WP  = 6;
  localparam int A_REG = 7;

  typedef struct packed {
    logic wp;
    logic se;
    logic cs;
    logic cle;
    logic ale;
  } pin_sel_t;

  typedef struct packed {
    logic nand_en;
    logic ce_en;
    logic cs_pol;
    logic se_pol;
    logic wp_pol;
    logic in_sel;
    logic out_sel;
  } ctl_t;
endpackage

// File: rtl/nbb_sync.sv
module nbb_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
  import nbb_pkg::*;
#(
  parameter int IO_W    = 8,
  parameter int WR_WAIT = 2,
  parameter int RD_WAIT = 2,
  parameter int HOLD    = 1,
  parameter int RECOV   = 1,
  parameter int CMULT   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            rd_i,
  input  pin_sel_t        sel_i,
  input  logic [IO_W-1:0] wdata_i,
  input  logic [IO_W-1:0] io_i,
  output logic            busy_o,
  output logic            ack_o,
  output pin_sel_t        sel_o,
  output logic            we_n_o,
  output logic            re_n_o,
  output logic [IO_W-1:0] io_o,
  output logic            io_oe_o,
  output logic [IO_W-1:0] rdata_o
);
  localparam int LW     = WR_WAIT * CMULT;
  localparam int LR     = RD_WAIT * CMULT;
  localparam int LH     = HOLD * CMULT;
  localparam int LV     = RECOV * CMULT;
  localparam int LMAX_A = (LW > LR) ? LW : LR;
  localparam int LMAX_B = (LH > LV) ? LH : LV;
  localparam int LMAX   = (LMAX_A > LMAX_B) ? LMAX_A : LMAX_B;
  localparam int CW     = $clog2(LMAX) + 1;

  seq_st_e         st_q;
  logic [CW-1:0]   cnt_q;
  logic            rd_q;
  pin_sel_t        sel_q;
  logic [IO_W-1:0] wd_q, rd_data_q;
  logic            cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      sel_q     <= '0;
      wd_q      <= '0;
      rd_data_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_STRB;
          cnt_q <= rd_i ? CW'(LR - 1) : CW'(LW - 1);
          rd_q  <= rd_i;
          sel_q <= sel_i;
          wd_q  <= wdata_i;
        end
        ST_STRB: if (cnt_zero) begin
          st_q  <= ST_HOLD;
          cnt_q <= CW'(LH - 1);
          if (rd_q) rd_data_q <= io_i;  // strobe rises at this edge
        end else cnt_q <= cnt_q - 1'b1;
        ST_HOLD: if (cnt_zero) begin
          st_q  <= ST_RCV;
          cnt_q <= CW'(LV - 1);
        end else cnt_q <= cnt_q - 1'b1;
        ST_RCV: if (cnt_zero) st_q <= ST_ACK;
                else cnt_q <= cnt_q - 1'b1;
        ST_ACK: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q == ST_STRB) || (st_q == ST_HOLD) || (st_q == ST_RCV);
  assign ack_o   = (st_q == ST_ACK);
  assign sel_o   = busy_o ? sel_q : '0;
  assign we_n_o  = !((st_q == ST_STRB) && !rd_q);
  assign re_n_o  = !((st_q == ST_STRB) && rd_q);
  assign io_oe_o = !rd_q && ((st_q == ST_STRB) || (st_q == ST_HOLD));
  assign io_o    = wd_q;
  assign rdata_o = rd_data_q;

  AST_WE_RISE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> io_oe_o); // R3
  AST_READ_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_n_o |-> !io_oe_o); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R5
endmodule

// File: rtl/nbb_regs.sv
module nbb_regs
  import nbb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          ctl_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          xfer_start_i,
  input  logic          xfer_end_i,
  input  logic [1:0]    rb_sync_i,
  output ctl_t          ctl_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [DW-1:0] CTL_MASK = DW'((1 << CTL_NANDM) | (1 << CTL_CSP) |
    (1 << CTL_SEP) | (1 << CTL_WPP) | (1 << CTL_INSEL) | (1 << CTL_OUTSEL) |
    (1 << CTL_CE));

  logic [DW-1:0] ctl_q;
  logic          done_q;
  logic [DW-1:0] sts;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_i && ctl_sel_i) ctl_q <= wdata_i & CTL_MASK;
      if (xfer_start_i)    done_q <= 1'b0;
      else if (xfer_end_i) done_q <= 1'b1;
    end
  end

  assign ctl_o.nand_en = ctl_q[CTL_NANDM];
  assign ctl_o.ce_en   = ctl_q[CTL_CE];
  assign ctl_o.cs_pol  = ctl_q[CTL_CSP];
  assign ctl_o.se_pol  = ctl_q[CTL_SEP];
  assign ctl_o.wp_pol  = ctl_q[CTL_WPP];
  assign ctl_o.in_sel  = ctl_q[CTL_INSEL];
  assign ctl_o.out_sel = ctl_q[CTL_OUTSEL];

  always_comb begin
    sts           = '0;
    sts[STS_RB]   = ctl_q[CTL_INSEL] ? rb_sync_i[1] : rb_sync_i[0];
    sts[STS_DONE] = done_q;
  end

  assign rdata_o = ctl_sel_i ? ctl_q : sts;

  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_i |=> done_q); // R6
  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_i |=> !done_q); // R6
endmodule

// File: rtl/nand_bus_bridge.sv
module nand_bus_bridge
  import nbb_pkg::*;
#(
  parameter int BUS_DW  = 32,
  parameter int IO_W    = 8,
  parameter int WR_WAIT = 2,
  parameter int RD_WAIT = 2,
  parameter int HOLD    = 1,
  parameter int RECOV   = 1,
  parameter int CMULT   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:2]        addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  output logic [BUS_DW-1:0] rdata_o,
  output logic              ready_o,
  output logic [1:0]        nand_ce_o,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_se_o,
  output logic              nand_wp_o,
  output logic              nand_we_n_o,
  output logic              nand_re_n_o,
  input  logic [IO_W-1:0]   nand_io_i,
  output logic [IO_W-1:0]   nand_io_o,
  output logic              nand_io_oe_o,
  input  logic [1:0]        nand_rb_i
);
  logic              seq_busy, seq_ack, reg_ack_q, idle_ok;
  logic              xfer_go, reg_go;
  logic [BUS_DW-1:0] reg_rd, reg_rd_q;
  logic [IO_W-1:0]   seq_rd;
  logic [1:0]        rb_sync;
  pin_sel_t          addr_sel, pin_sel;
  ctl_t              ctl;
  logic              cs_act;

  assign idle_ok = !seq_busy && !seq_ack && !reg_ack_q;
  assign xfer_go = req_i && !addr_i[A_REG] && idle_ok;
  assign reg_go  = req_i &&  addr_i[A_REG] && idle_ok;

  assign addr_sel.wp  = addr_i[A_WP];
  assign addr_sel.se  = addr_i[A_SE];
  assign addr_sel.cs  = addr_i[A_CS];
  assign addr_sel.cle = addr_i[A_CLE];
  assign addr_sel.ale = addr_i[A_ALE];

  nbb_sync #(.W(2)) u_rb_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(nand_rb_i), .q_o(rb_sync)
  );

  nbb_regs #(.DW(BUS_DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_go && we_i),
    .ctl_sel_i   (addr_i[2]),
    .wdata_i     (wdata_i),
    .xfer_start_i(xfer_go),
    .xfer_end_i  (seq_ack),
    .rb_sync_i   (rb_sync),
    .ctl_o       (ctl),
    .rdata_o     (reg_rd)
  );

  nbb_seq #(
    .IO_W(IO_W), .WR_WAIT(WR_WAIT), .RD_WAIT(RD_WAIT),
    .HOLD(HOLD), .RECOV(RECOV), .CMULT(CMULT)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(xfer_go),
    .rd_i   (!we_i),
    .sel_i  (addr_sel),
    .wdata_i(wdata_i[IO_W-1:0]),
    .io_i   (nand_io_i),
    .busy_o (seq_busy),
    .ack_o  (seq_ack),
    .sel_o  (pin_sel),
    .we_n_o (nand_we_n_o),
    .re_n_o (nand_re_n_o),
    .io_o   (nand_io_o),
    .io_oe_o(nand_io_oe_o),
    .rdata_o(seq_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_ack_q <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      reg_ack_q <= reg_go;
      if (reg_go) reg_rd_q <= reg_rd;
    end
  end

  assign ready_o = reg_ack_q || seq_ack;
  assign rdata_o = reg_ack_q ? reg_rd_q : {{(BUS_DW-IO_W){1'b0}}, seq_rd};

  // polarity bit set -> pin is active low
  assign cs_act       = ctl.nand_en && (ctl.ce_en || pin_sel.cs);
  assign nand_ce_o[0] = (cs_act && !ctl.out_sel) ^ ctl.cs_pol;
  assign nand_ce_o[1] = (cs_act &&  ctl.out_sel) ^ ctl.cs_pol;
  assign nand_cle_o   = pin_sel.cle;
  assign nand_ale_o   = pin_sel.ale;
  assign nand_se_o    = pin_sel.se ^ ctl.se_pol;
  assign nand_wp_o    = pin_sel.wp ^ ctl.wp_pol;

  AST_NO_READY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy |-> !ready_o); // R5
  AST_CE_OFF_NO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.nand_en |-> (nand_ce_o == {2{ctl.cs_pol}})); // R8
  AST_LATCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_we_n_o && nand_re_n_o && !nand_io_oe_o && !seq_busy)
      |-> (!nand_cle_o && !nand_ale_o)); // R1
endmodule

// File: tb/sim_nand_bus_bridge.sv
`timescale 1ns/1ps
module sim_nand_bus_bridge;
  localparam int M = 4, WW = 2, RW = 2, HH = 1, VV = 1;
  localparam int LAT = (WW + HH + VV) * M + 1;

  // [24] read, [23:16] byte addr, [15:8] data/io, [4:0] {wp,se,ce0,cle,ale}
  localparam logic [24:0] VEC [7] = '{
    {1'b0, 8'h18, 8'h70, 3'b0, 5'b00110},
    {1'b0, 8'h14, 8'h3C, 3'b0, 5'b00101},
    {1'b0, 8'h10, 8'hA5, 3'b0, 5'b00100},
    {1'b1, 8'h10, 8'h5A, 3'b0, 5'b00100},
    {1'b0, 8'h30, 8'h0F, 3'b0, 5'b01100},
    {1'b0, 8'h50, 8'hF0, 3'b0, 5'b10100},
    {1'b1, 8'h00, 8'hC3, 3'b0, 5'b00000}
  };

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [7:0] baddr = 0;
  logic [31:0] wdata = 0, rdata;
  logic ready;
  logic [1:0] ce, rb = 2'b11;
  logic cle, ale, se, wp, we_n, re_n, io_oe;
  logic [7:0] io_in = 0, io_out;

  int total = 0, bad = 0;
  bit finished = 0;
  int lat, we_lo, re_lo, drv;
  logic [1:0] cap_ce;
  logic cap_cle, cap_ale, cap_se, cap_wp;
  logic [31:0] rd_val;

  always #2.5 clk = ~clk;

  nand_bus_bridge u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(baddr[7:2]),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .nand_ce_o(ce), .nand_cle_o(cle), .nand_ale_o(ale), .nand_se_o(se),
    .nand_wp_o(wp), .nand_we_n_o(we_n), .nand_re_n_o(re_n),
    .nand_io_i(io_in), .nand_io_o(io_out), .nand_io_oe_o(io_oe), .nand_rb_i(rb)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [7:0] a, input logic [7:0] d);
    bit was_lo = 0;
    @(negedge clk);
    baddr = a; we = !rd; wdata = {24'h0, d}; io_in = d; req = 1;
    lat = 0; we_lo = 0; re_lo = 0; drv = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        cap_ce = ce; cap_cle = cle; cap_ale = ale; cap_se = se; cap_wp = wp;
      end
      if (!we_n) we_lo++;
      if (!re_n) begin re_lo++; was_lo = 1; end
      else if (was_lo) io_in = ~d;  // changes only after the strobe rose
      if (io_oe && io_out == d) drv++;
      if (ready) begin rd_val = rdata; req = 0; break; end
    end
  endtask

  task automatic reg_acc(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    baddr = a; we = w; wdata = d; req = 1;
    lat = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      lat++;
      if (ready) begin rd_val = rdata; req = 0; break; end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state
    #12;
    chk(ready == 0, "R5 ready in reset", ready, 0);
    chk(we_n && re_n && !io_oe, "R3 strobes idle in reset", {we_n, re_n, io_oe}, 3'b110);
    chk(ce == 2'b00 && !cle && !ale, "R8 pins idle in reset", {ce, cle, ale}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);

    reg_acc(0, 8'h84, 0);
    chk(rd_val == 0, "R11 control reset", rd_val, 0);
    chk(lat == 1, "R11 register ack latency", lat, 1);
    reg_acc(0, 8'h80, 0);
    chk(rd_val == 32'h1, "R6 status after reset (done 0, rb 1)", rd_val, 32'h1);
    reg_acc(1, 8'h84, 32'hFFFF_FFFF);
    reg_acc(0, 8'h84, 0);
    chk(rd_val == 32'h0010_0571, "R11 control write mask", rd_val, 32'h0010_0571);

    // vector table, flash mode only
    reg_acc(1, 8'h84, 32'h1);
    for (int i = 0; i < 7; i++) begin
      logic [24:0] v;
      v = VEC[i];
      xfer(v[24], v[23:16], v[15:8]);
      chk(lat == LAT, "R5 access latency", lat, LAT);
      chk({cap_wp, cap_se, cap_ce[0], cap_cle, cap_ale} == v[4:0],
          "R1 R2 pins during strobe", {cap_wp, cap_se, cap_ce[0], cap_cle, cap_ale}, v[4:0]);
      if (v[24]) begin
        chk(re_lo == RW * M && we_lo == 0, "R4 read strobe length", re_lo, RW * M);
        chk(drv == 0, "R4 no drive on read", drv, 0);
        chk(rd_val[7:0] == v[15:8], "R4 read data at strobe rise", rd_val, v[15:8]);
      end else begin
        chk(we_lo == WW * M && re_lo == 0, "R3 write strobe length", we_lo, WW * M);
        chk(drv == (WW + HH) * M, "R3 data driven strobe plus hold", drv, (WW + HH) * M);
      end
      @(negedge clk);
      chk(!ready, "R5 ready single pulse", ready, 0);
      chk(!cle && !ale && se == 0 && wp == 0, "R1 R2 idle after transfer",
          {cle, ale, se, wp}, 0);
      reg_acc(0, 8'h80, 0);
      chk(rd_val[3] == 1'b1, "R6 done set after transfer", rd_val[3], 1);
    end

    // chip enable control
    reg_acc(1, 8'h84, 32'h0010_0001);
    @(negedge clk);
    chk(ce == 2'b01, "R8 mode plus enable asserts ce", ce, 2'b01);
    reg_acc(1, 8'h84, 32'h0010_0000);
    @(negedge clk);
    chk(ce == 2'b00, "R8 enable without mode stays off", ce, 2'b00);
    xfer(0, 8'h10, 8'h11);
    chk(cap_ce == 2'b00, "R8 no ce in transfer without mode", cap_ce, 2'b00);

    // routing
    reg_acc(1, 8'h84, 32'h0000_0501);
    xfer(0, 8'h10, 8'h22);
    chk(cap_ce == 2'b10, "R9 ce routed to line 1", cap_ce, 2'b10);
    rb = 2'b01;
    repeat (3) @(negedge clk);
    reg_acc(0, 8'h80, 0);
    chk(rd_val[0] == 1'b0, "R9 R7 rb from line 1", rd_val[0], 0);
    rb = 2'b10;
    repeat (3) @(negedge clk);
    reg_acc(0, 8'h80, 0);
    chk(rd_val[0] == 1'b1, "R9 R7 rb from line 1 high", rd_val[0], 1);
    reg_acc(1, 8'h84, 32'h1);
    reg_acc(0, 8'h80, 0);
    chk(rd_val[0] == 1'b0, "R7 rb from line 0", rd_val[0], 0);

    // polarity
    reg_acc(1, 8'h84, 32'h71);
    @(negedge clk);
    chk(ce == 2'b11 && se && wp, "R10 inactive levels inverted", {ce, se, wp}, 4'b1111);
    xfer(0, 8'h70, 8'h33);
    chk(cap_ce == 2'b10 && !cap_se && !cap_wp, "R10 active low during transfer",
        {cap_ce, cap_se, cap_wp}, 4'b1000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule